// File: doc/BRIEF.md
# SMM-Aware Memory Address Router

This block sits in a host bridge and decides, for every memory request, which target claims it: main DRAM, the firmware ROM bus, the external PCI bus, or nobody. A request carries an address, a write flag, a source code naming the bus that started it (host processor, external PCI, or one of the other peripheral buses) and a flag saying whether the processor is in system management mode. The decision is registered and comes back one cycle later together with the tag of the request, so a caller can match results to requests.

Three kinds of window shape the answer. The legacy video window at A0000h–BFFFFh belongs to PCI in normal operation and to DRAM in management mode. The firmware area at C0000h–FFFFFh is split into segments, each with its own read and write redirect bits, so firmware can be copied into DRAM and then run from there. A protected segment just below top of memory, sized 128 KB to 1 MB, is reachable in DRAM only by host requests made in management mode. Requests from buses other than the host may only reach main memory; anything else is left unclaimed.

Top of memory, the segment redirect bits and the protected-segment controls live in a four-entry register file loaded through a simple write port.

Top module: `mem_addr_router`

## Requirements
- R1: A request with `req_valid` high at a rising edge produces `rsp_valid` high after exactly that edge, holding that request's tag; `rsp_valid` is low after every edge without a request.
- R2: After reset `rsp_valid` and `rsp_claim` are low, every redirect bit is clear, the protected segment is disabled and top of memory equals the `TOM_RESET` parameter.
- R3: Addresses below A0000h go to DRAM for every source and mode.
- R4: For A0000h–BFFFFh a host request goes to PCI outside management mode and to DRAM inside it; requests from any other source are unclaimed.
- R5: In C0000h–FFFFFh the segment index is the address offset from C0000h divided by the segment size (16 KB with 16 segments); a host read goes to DRAM when that segment's read bit is set, otherwise to ROM.
- R6: A host write in C0000h–FFFFFh follows the segment's write bit the same way, independent of its read bit.
- R7: With the write bit set and the read bit clear, reads of a segment go to ROM while writes to the same address go to DRAM; once the read bit is then set, reads go to DRAM.
- R8: Size code 00/01/10/11 selects 128 KB/256 KB/512 KB/1 MB; the protected segment spans [top − size, top). When enabled, host requests inside it go to PCI outside management mode and to DRAM inside it; when disabled they go to DRAM.
- R9: A host request at or above both 1 MB and top of memory goes to PCI.
- R10: External PCI requests are claimed only as DRAM: below A0000h, in a redirect segment whose bit for that operation is set, or in [1 MB, top), protected segment included; everything else is unclaimed.
- R11: Requests with source code 2 or 3 (other peripheral buses) follow the same main-memory-only rule as R10.
- R12: Register write port: address 0 holds read bits, 1 write bits (bit i = segment i), 2 top of memory (low 20 bits dropped), 3 protected-segment control (bits 1:0 size code, bit 2 enable). A write takes effect for requests after the write edge; a request in the same cycle sees the old value.
- R13: Target code is 0 none, 1 DRAM, 2 ROM, 3 PCI; source code is 0 host, 1 external PCI, 2/3 other; `rsp_claim` is high exactly when the target code is not 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | ADDR_W | Register write data |
| req_valid | input | 1 | Request present |
| req_tag | input | TAG_W | Request tag |
| req_addr | input | ADDR_W | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_src | input | 2 | Originating bus code |
| req_smm | input | 1 | Processor in management mode |
| rsp_valid | output | 1 | Result present |
| rsp_tag | output | TAG_W | Tag of the decoded request |
| rsp_target | output | 2 | Target code |
| rsp_claim | output | 1 | Request claimed |

## Verification
The bench builds the router with 32-bit addresses, 16 redirect segments and a top-of-memory reset value of 2 MB instead of the default. That small top puts the 1 MB protected segment exactly on the 1 MB boundary, so the largest size code meets the edge where the extended-memory range begins, and every size code places a base within easy reach of directed addresses. It also lets a top-of-memory rewrite to 4 MB move the PCI boundary in a way that a request issued in the same cycle must not yet see.

// File: rtl/mar_pkg.sv
package mar_pkg;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_DRAM = 2'd1,
        TGT_ROM  = 2'd2,
        TGT_PCI  = 2'd3
    } tgt_e;

    localparam logic [1:0] SRC_HOST = 2'd0;
    localparam logic [1:0] SRC_XPCI = 2'd1;

    localparam logic [1:0] REG_RDEN = 2'd0;
    localparam logic [1:0] REG_WREN = 2'd1;
    localparam logic [1:0] REG_TOP  = 2'd2;
    localparam logic [1:0] REG_PSEG = 2'd3;

endpackage

// File: rtl/mar_cfg_regs.sv
module mar_cfg_regs #(
    parameter int ADDR_W    = 32,
    parameter int SEG_N     = 16,
    parameter logic [ADDR_W-1:0] TOM_RESET = 32'h0100_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        waddr,
    input  logic [ADDR_W-1:0] wdata,
    output logic [SEG_N-1:0]  rd_en,
    output logic [SEG_N-1:0]  wr_en,
    output logic [ADDR_W-1:0] tom,
    output logic              pseg_en,
    output logic [1:0]        pseg_size
);
    import mar_pkg::*;

    localparam int MB_BITS = 20;

    typedef struct packed {
        logic [SEG_N-1:0]  rden;
        logic [SEG_N-1:0]  wren;
        logic [ADDR_W-1:0] top;
        logic              pen;
        logic [1:0]        psize;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            unique case (waddr)
                REG_RDEN: cfg_d.rden  = wdata[SEG_N-1:0];
                REG_WREN: cfg_d.wren  = wdata[SEG_N-1:0];
                REG_TOP:  cfg_d.top   = {wdata[ADDR_W-1:MB_BITS], {MB_BITS{1'b0}}};
                REG_PSEG: begin
                    cfg_d.psize = wdata[1:0];
                    cfg_d.pen   = wdata[2];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.rden  <= '0;
            cfg_q.wren  <= '0;
            cfg_q.top   <= {TOM_RESET[ADDR_W-1:MB_BITS], {MB_BITS{1'b0}}};
            cfg_q.pen   <= 1'b0;
            cfg_q.psize <= 2'b00;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    logic wdata_unused;
    assign wdata_unused = ^{wdata[MB_BITS-1:SEG_N], wdata[MB_BITS-1:3]};

    assign rd_en     = cfg_q.rden;
    assign wr_en     = cfg_q.wren;
    assign tom       = cfg_q.top;
    assign pseg_en   = cfg_q.pen;
    assign pseg_size = cfg_q.psize;

    // R12
    top_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(we) && $past(waddr) == REG_TOP
        |-> tom[ADDR_W-1:MB_BITS] == $past(wdata[ADDR_W-1:MB_BITS]));

endmodule

// File: rtl/mar_window.sv
module mar_window #(
    parameter int ADDR_W = 32,
    parameter int SEG_N  = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] tom,
    input  logic              pseg_en,
    input  logic [1:0]        pseg_size,
    output logic              in_low,
    output logic              in_vga,
    output logic              in_fw,
    output logic [SEG_N-1:0]  seg_hit,
    output logic              in_ext,
    output logic              in_pseg
);
    localparam int SEG_BITS  = $clog2(SEG_N);
    localparam int SEG_SHIFT = 18 - SEG_BITS;
    localparam logic [ADDR_W-1:0] VGA_BASE = ADDR_W'(32'h000A_0000);
    localparam logic [ADDR_W-1:0] FW_BASE  = ADDR_W'(32'h000C_0000);
    localparam logic [ADDR_W-1:0] EXT_BASE = ADDR_W'(32'h0010_0000);
    localparam logic [ADDR_W-1:0] SZ_MIN   = ADDR_W'(32'h0002_0000);

    logic [ADDR_W-1:0]   pseg_bytes;
    logic [ADDR_W-1:0]   pseg_base;
    logic [SEG_BITS-1:0] seg_idx;

    always_comb begin
        in_low     = addr < VGA_BASE;
        in_vga     = (addr >= VGA_BASE) && (addr < FW_BASE);
        in_fw      = (addr >= FW_BASE) && (addr < EXT_BASE);
        in_ext     = (addr >= EXT_BASE) && (addr < tom);
        pseg_bytes = SZ_MIN << pseg_size;
        pseg_base  = tom - pseg_bytes;
        in_pseg    = pseg_en && in_ext && (addr >= pseg_base);
        seg_idx    = addr[17:SEG_SHIFT];
    end

    for (genvar g = 0; g < SEG_N; g++) begin : g_seg
        assign seg_hit[g] = in_fw && (seg_idx == SEG_BITS'(g));
    end

endmodule

// File: rtl/mar_policy.sv
module mar_policy #(
    parameter int SEG_N = 16
) (
    input  logic             in_low,
    input  logic             in_vga,
    input  logic             in_fw,
    input  logic [SEG_N-1:0] seg_hit,
    input  logic             in_ext,
    input  logic             in_pseg,
    input  logic [SEG_N-1:0] rd_en,
    input  logic [SEG_N-1:0] wr_en,
    input  logic             write,
    input  logic [1:0]       src,
    input  logic             smm,
    output mar_pkg::tgt_e    target
);
    import mar_pkg::*;

    logic host;
    logic redirect;

    always_comb begin
        host     = (src == SRC_HOST);
        redirect = write ? |(seg_hit & wr_en) : |(seg_hit & rd_en);
        if (in_low) begin
            target = TGT_DRAM;
        end else if (in_vga) begin
            if (!host)     target = TGT_NONE;
            else if (smm)  target = TGT_DRAM;
            else           target = TGT_PCI;
        end else if (in_fw) begin
            if (redirect)  target = TGT_DRAM;
            else if (host) target = TGT_ROM;
            else           target = TGT_NONE;
        end else if (in_ext) begin
            target = (host && in_pseg && !smm) ? TGT_PCI : TGT_DRAM;
        end else begin
            target = host ? TGT_PCI : TGT_NONE;
        end
    end

endmodule

// File: rtl/mem_addr_router.sv
module mem_addr_router #(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 4,
    parameter int SEG_N  = 16,
    parameter logic [ADDR_W-1:0] TOM_RESET = 32'h0100_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              req_valid,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [1:0]        req_src,
    input  logic              req_smm,
    output logic              rsp_valid,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic [1:0]        rsp_target,
    output logic              rsp_claim
);
    import mar_pkg::*;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        tgt_e             tgt;
    } rsp_t;

    logic [SEG_N-1:0]  rd_en, wr_en, seg_hit;
    logic [ADDR_W-1:0] tom;
    logic              pseg_en;
    logic [1:0]        pseg_size;
    logic              in_low, in_vga, in_fw, in_ext, in_pseg;
    tgt_e              tgt_next;
    rsp_t              rsp_d, rsp_q;

    mar_cfg_regs #(.ADDR_W(ADDR_W), .SEG_N(SEG_N), .TOM_RESET(TOM_RESET)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_addr), .wdata(cfg_wdata),
        .rd_en(rd_en), .wr_en(wr_en), .tom(tom), .pseg_en(pseg_en), .pseg_size(pseg_size)
    );

    mar_window #(.ADDR_W(ADDR_W), .SEG_N(SEG_N)) u_win (
        .addr(req_addr), .tom(tom), .pseg_en(pseg_en), .pseg_size(pseg_size),
        .in_low(in_low), .in_vga(in_vga), .in_fw(in_fw), .seg_hit(seg_hit),
        .in_ext(in_ext), .in_pseg(in_pseg)
    );

    mar_policy #(.SEG_N(SEG_N)) u_pol (
        .in_low(in_low), .in_vga(in_vga), .in_fw(in_fw), .seg_hit(seg_hit),
        .in_ext(in_ext), .in_pseg(in_pseg), .rd_en(rd_en), .wr_en(wr_en),
        .write(req_write), .src(req_src), .smm(req_smm), .target(tgt_next)
    );

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            rsp_d.tag = req_tag;
            rsp_d.tgt = tgt_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q.valid <= 1'b0;
            rsp_q.tag   <= '0;
            rsp_q.tgt   <= TGT_NONE;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid  = rsp_q.valid;
    assign rsp_tag    = rsp_q.tag;
    assign rsp_target = rsp_q.tgt;
    assign rsp_claim  = rsp_q.valid && (rsp_q.tgt != TGT_NONE);

    // R1
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> rsp_valid == $past(req_valid));

    // R1
    tag_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && rsp_valid |-> rsp_tag == $past(req_tag));

    // R3
    low_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && rsp_valid && $past(in_low) |-> rsp_target == TGT_DRAM);

    // R4
    vga_smm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && rsp_valid && $past(in_vga && req_smm && req_src == SRC_HOST)
        |-> rsp_target == TGT_DRAM);

    // R8
    pseg_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && rsp_valid && $past(in_pseg && !req_smm && req_src == SRC_HOST)
        |-> rsp_target == TGT_PCI);

    // R10
    nonhost_mem_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && rsp_valid && $past(req_src) != SRC_HOST
        |-> rsp_target == TGT_NONE || rsp_target == TGT_DRAM);

endmodule

// File: tb/tb_mem_addr_router.sv
module tb_mem_addr_router;

    localparam int ADDR_W = 32;
    localparam int TAG_W  = 4;
    localparam int SEG_N  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_addr = '0;
    logic [ADDR_W-1:0] cfg_wdata = '0;
    logic              req_valid = 1'b0;
    logic [TAG_W-1:0]  req_tag = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_write = 1'b0;
    logic [1:0]        req_src = '0;
    logic              req_smm = 1'b0;
    logic              rsp_valid;
    logic [TAG_W-1:0]  rsp_tag;
    logic [1:0]        rsp_target;
    logic              rsp_claim;

    int checks = 0;
    int errors = 0;
    int tag_ctr = 0;

    // reference configuration state
    bit [15:0]   m_rd = '0;
    bit [15:0]   m_wr = '0;
    int unsigned m_top = 32'h0020_0000;
    bit          m_pen = 0;
    int unsigned m_psz = 0;

    always #5 clk = ~clk;

    mem_addr_router #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .SEG_N(SEG_N),
                      .TOM_RESET(32'h0020_0000)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_tag(req_tag),
        .req_addr(req_addr), .req_write(req_write), .req_src(req_src),
        .req_smm(req_smm), .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
        .rsp_target(rsp_target), .rsp_claim(rsp_claim)
    );

    // 0 none, 1 dram, 2 rom, 3 pci
    function automatic int ref_tgt(int unsigned a, bit w, int s, bit m);
        bit host = (s == 0);
        int unsigned seg;
        bit on;
        if (a < 32'hA0000) return 1;
        if (a < 32'hC0000) return host ? (m ? 1 : 3) : 0;
        if (a < 32'h100000) begin
            seg = (a - 32'hC0000) / 16384;
            on  = w ? m_wr[seg] : m_rd[seg];
            if (on) return 1;
            return host ? 2 : 0;
        end
        if (a < m_top) begin
            if (host && !m && m_pen && a >= m_top - (32'h20000 << m_psz)) return 3;
            return 1;
        end
        return host ? 3 : 0;
    endfunction

    task automatic cycle(input bit v, input int unsigned a, input bit w, input int s,
                         input bit m, input bit cwe, input int ca, input int unsigned cd,
                         input string rq);
        int exp_t;
        logic [TAG_W-1:0] exp_tag;
        exp_tag   = TAG_W'(tag_ctr);
        req_valid = v;
        req_tag   = exp_tag;
        req_addr  = a;
        req_write = w;
        req_src   = 2'(s);
        req_smm   = m;
        cfg_we    = cwe;
        cfg_addr  = 2'(ca);
        cfg_wdata = cd;
        exp_t     = v ? ref_tgt(a, w, s, m) : 0;
        @(negedge clk);
        if (cwe) begin
            case (ca)
                0: m_rd = cd[15:0];
                1: m_wr = cd[15:0];
                2: m_top = cd & 32'hFFF0_0000;
                default: begin m_pen = cd[2]; m_psz = cd[1:0]; end
            endcase
        end
        req_valid = 1'b0;
        cfg_we    = 1'b0;
        tag_ctr++;
        checks++;
        if (rsp_valid !== v ||
            (v && (rsp_tag !== exp_tag || rsp_target !== 2'(exp_t) ||
                   rsp_claim !== (exp_t != 0))) ||
            (!v && rsp_claim !== 1'b0)) begin
            errors++;
            $display("FAIL %s addr=%h src=%0d wr=%0b smm=%0b: valid/tag/target/claim actual %0b/%0d/%0d/%0b expected %0b/%0d/%0d/%0b",
                     rq, a, s, w, m, rsp_valid, rsp_tag, rsp_target, rsp_claim,
                     v, exp_tag, exp_t, (v && exp_t != 0));
        end
    endtask

    task automatic rd(input int unsigned a, input int s, input bit m, input string rq);
        cycle(1, a, 0, s, m, 0, 0, 0, rq);
    endtask

    task automatic wt(input int unsigned a, input int s, input bit m, input string rq);
        cycle(1, a, 1, s, m, 0, 0, 0, rq);
    endtask

    task automatic cfg(input int ca, input int unsigned cd, input string rq);
        cycle(0, 0, 0, 0, 0, 1, ca, cd, rq);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || rsp_claim !== 1'b0) begin
            errors++;
            $display("FAIL R2 reset outputs: actual %0b/%0b expected 0/0", rsp_valid, rsp_claim);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset configuration
        rd(32'h000C_0000, 0, 0, "R2 rom default read");
        wt(32'h000D_0000, 0, 0, "R2 rom default write");
        rd(32'h001F_FFFC, 0, 0, "R2 top reset dram");
        rd(32'h0020_0000, 0, 0, "R2 R9 top reset pci");
        // R3 low memory
        rd(32'h0000_0000, 0, 0, "R3 host low");
        wt(32'h0009_FFFF, 1, 0, "R3 xpci low");
        rd(32'h0005_0000, 2, 1, "R3 peri low");
        // R4 video window
        rd(32'h000A_0000, 0, 0, "R4 host normal");
        wt(32'h000B_FFFF, 0, 1, "R4 host smm");
        rd(32'h000A_0000, 1, 1, "R4 xpci");
        rd(32'h000B_0000, 3, 0, "R4 peri");
        // R1 idle then back-to-back
        cycle(0, 0, 0, 0, 0, 0, 0, 0, "R1 idle");
        rd(32'h0000_1000, 0, 0, "R1 back to back a");
        rd(32'h000A_1000, 0, 0, "R1 back to back b");
        // R5 R12 read redirect on segment 3
        cfg(0, 32'h0000_0008, "R12 write rd bits");
        rd(32'h000C_C000, 0, 0, "R5 seg3 start");
        rd(32'h000C_FFFF, 0, 0, "R5 seg3 end");
        rd(32'h000C_8000, 0, 0, "R5 seg2 rom");
        wt(32'h000C_C000, 0, 0, "R6 write bit clear");
        // R7 copy sequence on segment 5
        cfg(1, 32'h0000_0020, "R12 write wr bits");
        rd(32'h000D_4000, 0, 0, "R7 copy read rom");
        wt(32'h000D_4000, 0, 0, "R7 copy write dram");
        cfg(0, 32'h0000_0028, "R12 rd bits after copy");
        rd(32'h000D_4000, 0, 0, "R7 after copy read");
        wt(32'h000C_C000, 0, 0, "R6 seg3 write still rom");
        // R10 external PCI
        rd(32'h000D_4000, 1, 0, "R10 xpci redirected");
        wt(32'h000D_7FFF, 1, 0, "R10 xpci write redirected");
        rd(32'h000C_0000, 1, 0, "R10 xpci firmware");
        rd(32'h000F_FFF0, 1, 0, "R10 xpci top firmware");
        rd(32'h0018_0000, 1, 0, "R10 xpci ext");
        rd(32'h0020_0000, 1, 0, "R10 xpci above top");
        // R11 other buses
        rd(32'h000D_4000, 2, 0, "R11 peri redirected");
        wt(32'h000E_0000, 3, 0, "R11 peri firmware");
        rd(32'h0030_0000, 2, 0, "R11 peri above top");
        rd(32'h0010_0000, 3, 1, "R11 peri ext");
        // R8 protected segment, every size code
        cfg(3, 32'h4, "R8 enable 128k");
        rd(32'h001E_0000, 0, 0, "R8 128k base normal");
        rd(32'h001D_FFFF, 0, 0, "R8 128k below base");
        rd(32'h001E_0000, 0, 1, "R8 128k smm");
        rd(32'h001F_0000, 1, 0, "R8 R10 xpci in segment");
        cfg(3, 32'h5, "R8 256k");
        rd(32'h001C_0000, 0, 0, "R8 256k base");
        rd(32'h001B_FFFF, 0, 0, "R8 256k below");
        cfg(3, 32'h6, "R8 512k");
        rd(32'h0018_0000, 0, 0, "R8 512k base");
        wt(32'h0017_FFFF, 0, 0, "R8 512k below");
        cfg(3, 32'h7, "R8 1m");
        rd(32'h0010_0000, 0, 0, "R8 1m base");
        wt(32'h0010_0000, 0, 1, "R8 1m smm");
        rd(32'h0010_0000, 2, 0, "R8 R11 peri in segment");
        cfg(3, 32'h3, "R8 disable");
        rd(32'h0010_0000, 0, 0, "R8 disabled dram");
        // R12 same-cycle top write sees old value
        cycle(1, 32'h0030_0000, 0, 0, 0, 1, 2, 32'h004A_BCDE, "R12 same cycle top");
        rd(32'h0030_0000, 0, 0, "R12 new top dram");
        rd(32'h003F_FFFF, 0, 0, "R12 top low bits dropped");
        rd(32'h0040_0000, 0, 0, "R9 new top pci");

        // mixed stimulus
        for (int i = 0; i < 400; i++) begin
            int unsigned a;
            int k = $urandom_range(0, 5);
            case (k)
                0: a = $urandom_range(0, 32'h9FFFF);
                1: a = $urandom_range(32'hA0000, 32'hBFFFF);
                2: a = $urandom_range(32'hC0000, 32'hFFFFF);
                3: a = $urandom_range(32'h100000, 32'h3FFFFF);
                default: a = $urandom_range(32'h1C0000, 32'h4FFFFF);
            endcase
            if ($urandom_range(0, 7) == 0) begin
                int ca = $urandom_range(0, 3);
                int unsigned cd = $urandom;
                if (ca == 2) cd = ($urandom_range(0, 1) != 0) ? 32'h0020_0000 : 32'h0040_0000;
                cycle($urandom_range(0, 1), a, $urandom_range(0, 1), $urandom_range(0, 3),
                      $urandom_range(0, 1), 1, ca, cd, "R12 mixed with write");
            end else begin
                cycle($urandom_range(0, 4) != 0, a, $urandom_range(0, 1),
                      $urandom_range(0, 3), $urandom_range(0, 1), 0, 0, 0, "R13 mixed");
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule